// File: doc/BRIEF.md
# Move-to-Front Recency Stack for Page Replacement

This block keeps the resident page addresses of a small primary memory in recency order. Slot 0 holds the page touched most recently and the deepest slot holds the one touched longest ago. Every slot compares its stored address with a presented reference key at the same time. A match lifts that entry to slot 0, and every entry that was above it slides one slot deeper. Entries below the match keep their slots. The replacement candidate is read straight from the stack and is always on the outputs.

A separate push path loads a freshly fetched page into slot 0. All entries move one slot deeper and the deepest entry falls off. Each slot carries a valid flag. Valid entries always fill the stack from slot 0 downward, so an empty slot, when there is one, is the first replacement choice. The hit, miss and position outputs are combinational from the current stack and the reference key. The reorder takes effect at the next clock edge. One reference or one push can be accepted per cycle.

Top module: `lru_mtf_stack`

## Requirements
- R1: While `rst_n` is low, every slot is invalid, `victim_empty` is 1, `victim_pos` is 0 and `victim_addr` is 0. After reset, no reference key matches until a push has occurred.
- R2: When `ref_valid` is 1 and `ins_valid` is 0, `hit` or `miss` is 1 in the same cycle, and never both. On a hit, `hit_pos` gives the slot that holds the key.
- R3: After a hit at slot i > 0, slot 0 holds the key on the next cycle and each former slot k < i sits at slot k+1.
- R4: After a hit at slot i, every slot deeper than i keeps its address and its valid flag.
- R5: A hit at slot 0 leaves the whole stack unchanged.
- R6: A miss leaves the whole stack unchanged.
- R7: When `ins_valid` is 1, the next cycle has `ins_addr` valid in slot 0. Every former slot k sits at slot k+1, and the former deepest entry is discarded.
- R8: If any slot is invalid, `victim_empty` is 1, `victim_pos` equals the number of valid entries and `victim_addr` is 0. If every slot is valid, `victim_empty` is 0, `victim_pos` is DEPTH-1 and `victim_addr` is the deepest entry.
- R9: When `ins_valid` and `ref_valid` are both 1, the push is performed, the reference is ignored, and `hit` and `miss` both stay 0.
- R10: An invalid slot never matches, even when the key equals its stale contents or 0.
- R11: If several valid slots hold the key, the lowest-numbered slot is reported and promoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A reference key is presented this cycle |
| ref_addr | input | ADDR_W | Reference page address |
| ins_valid | input | 1 | Push a newly loaded page |
| ins_addr | input | ADDR_W | Page address to push |
| hit | output | 1 | Reference found in the stack |
| miss | output | 1 | Reference not found |
| hit_pos | output | $clog2(DEPTH) | Slot of the match (0 when no hit) |
| victim_empty | output | 1 | Replacement candidate is an empty slot |
| victim_pos | output | $clog2(DEPTH) | Slot of the replacement candidate |
| victim_addr | output | ADDR_W | Address of the candidate (0 if empty) |

## Verification
A wrong internal order does not show on the victim outputs at once. It becomes visible through `hit_pos` as soon as a key held in a displaced slot is presented, and that can happen in the very next cycle. The bench therefore presents every resident address after each step, holding `ref_valid` high only during the low clock phase so that nothing is committed. This reads the full order through the ports. A lost or duplicated entry shows up as a wrong valid count on `victim_pos` in the cycle after the faulty update. It also shows up as a miss on an address that should still be resident.

// File: rtl/lru_stack_pkg.sv
package lru_stack_pkg;

  // Update applied to the stack registers at the next edge.
  typedef enum logic [1:0] {
    UPD_KEEP    = 2'd0,
    UPD_PROMOTE = 2'd1,
    UPD_PUSH    = 2'd2
  } upd_e;

  // A push always wins; a promotion needs a matching reference.
  function automatic upd_e pick_update(input logic push_req,
                                       input logic ref_req,
                                       input logic found);
    if (push_req)            return UPD_PUSH;
    else if (ref_req && found) return UPD_PROMOTE;
    else                     return UPD_KEEP;
  endfunction

endpackage

// File: rtl/lru_match.sv
module lru_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] key,
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic              slot_valid [DEPTH],
  output logic [DEPTH-1:0]  match_vec,
  output logic              any_match,
  output logic [IDX_W-1:0]  match_idx,
  output logic [ADDR_W-1:0] match_addr
);

  // One comparator per slot, all working in parallel.
  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign match_vec[s] = slot_valid[s] && (slot_addr[s] == key);
  end

  // Lowest slot number wins when the key is held more than once.
  function automatic logic [IDX_W-1:0] first_set(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = DEPTH-1; k >= 0; k--) begin
      if (v[k]) idx = IDX_W'(k);
    end
    return idx;
  endfunction

  assign any_match = |match_vec;
  assign match_idx = first_set(match_vec);

  // Holding value for the entry that is about to move to the top.
  assign match_addr = slot_addr[match_idx];

endmodule

// File: rtl/lru_victim.sv
module lru_victim #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic              slot_valid [DEPTH],
  output logic              empty_slot,
  output logic [IDX_W-1:0]  pos,
  output logic [ADDR_W-1:0] addr
);

  logic [DEPTH-1:0] free_vec;

  for (genvar s = 0; s < DEPTH; s++) begin : g_free
    assign free_vec[s] = !slot_valid[s];
  end

  // Valid entries fill from slot 0, so the first free slot equals the count.
  function automatic logic [IDX_W-1:0] first_free(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = IDX_W'(DEPTH-1);
    for (int k = DEPTH-1; k >= 0; k--) begin
      if (v[k]) idx = IDX_W'(k);
    end
    return idx;
  endfunction

  assign empty_slot = |free_vec;
  assign pos        = first_free(free_vec);
  assign addr       = empty_slot ? '0 : slot_addr[DEPTH-1];

endmodule

// File: rtl/lru_stack_regs.sv
module lru_stack_regs
  import lru_stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_e              upd,
  input  logic [IDX_W-1:0]  promote_idx,
  input  logic [ADDR_W-1:0] promote_addr,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic              slot_valid [DEPTH]
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    if (s == 0) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_addr[s]  <= '0;
          slot_valid[s] <= 1'b0;
        end else begin
          case (upd)
            UPD_PUSH: begin
              slot_addr[s]  <= push_addr;
              slot_valid[s] <= 1'b1;
            end
            UPD_PROMOTE: begin
              slot_addr[s]  <= promote_addr;
              slot_valid[s] <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end else begin : g_lower
      // Slot s takes its upper neighbour on a push, or on a promotion
      // from slot s or deeper; otherwise it holds.
      logic shift_in;
      assign shift_in = (upd == UPD_PUSH) ||
                        ((upd == UPD_PROMOTE) && (promote_idx >= IDX_W'(s)));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_addr[s]  <= '0;
          slot_valid[s] <= 1'b0;
        end else if (shift_in) begin
          slot_addr[s]  <= slot_addr[s-1];
          slot_valid[s] <= slot_valid[s-1];
        end
      end
    end
  end

endmodule

// File: rtl/lru_mtf_stack.sv
module lru_mtf_stack
  import lru_stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SLOT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  output logic              hit,
  output logic              miss,
  output logic [IDX_W-1:0]  hit_pos,
  output logic              victim_empty,
  output logic [IDX_W-1:0]  victim_pos,
  output logic [ADDR_W-1:0] victim_addr
);

  logic [ADDR_W-1:0] slot_addr  [DEPTH];
  logic              slot_valid [DEPTH];
  logic [DEPTH-1:0]  match_vec;
  logic              any_match;
  logic [IDX_W-1:0]  match_idx;
  logic [ADDR_W-1:0] hold_addr;
  upd_e              upd;

  // Named events for the checker.
  logic                    lookup_en;
  logic [ADDR_W-1:0]       top_addr;
  logic                    top_valid;
  logic [DEPTH*SLOT_W-1:0] stack_flat;

  lru_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .key        (ref_addr),
    .slot_addr  (slot_addr),
    .slot_valid (slot_valid),
    .match_vec  (match_vec),
    .any_match  (any_match),
    .match_idx  (match_idx),
    .match_addr (hold_addr)
  );

  assign lookup_en = ref_valid && !ins_valid;
  assign hit       = lookup_en && any_match;
  assign miss      = lookup_en && !any_match;
  assign hit_pos   = hit ? match_idx : '0;
  assign upd       = pick_update(ins_valid, ref_valid, any_match);

  lru_stack_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd          (upd),
    .promote_idx  (match_idx),
    .promote_addr (hold_addr),
    .push_addr    (ins_addr),
    .slot_addr    (slot_addr),
    .slot_valid   (slot_valid)
  );

  lru_victim #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_victim (
    .slot_addr  (slot_addr),
    .slot_valid (slot_valid),
    .empty_slot (victim_empty),
    .pos        (victim_pos),
    .addr       (victim_addr)
  );

  assign top_addr  = slot_addr[0];
  assign top_valid = slot_valid[0];

  for (genvar s = 0; s < DEPTH; s++) begin : g_flat
    assign stack_flat[s*SLOT_W +: SLOT_W] = {slot_valid[s], slot_addr[s]};
  end

endmodule

// File: rtl/lru_mtf_stack_chk.sv
module lru_mtf_stack_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SLOT_W = ADDR_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_valid,
  input logic [ADDR_W-1:0]       ref_addr,
  input logic                    ins_valid,
  input logic [ADDR_W-1:0]       ins_addr,
  input logic                    hit,
  input logic                    miss,
  input logic [IDX_W-1:0]        hit_pos,
  input logic                    victim_empty,
  input logic [IDX_W-1:0]        victim_pos,
  input logic [ADDR_W-1:0]       victim_addr,
  input logic [ADDR_W-1:0]       top_addr,
  input logic                    top_valid,
  input logic [DEPTH*SLOT_W-1:0] stack_flat
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (victim_empty && victim_pos == '0 && victim_addr == '0));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss}) && ((ref_valid && !ins_valid) == (hit || miss)));

  assert_hit_to_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (top_valid && top_addr == $past(ref_addr)));

  assert_top_hit_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_pos == '0) |=> (stack_flat == $past(stack_flat)));

  assert_miss_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (stack_flat == $past(stack_flat)));

  assert_push_to_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> (top_valid && top_addr == $past(ins_addr)));

  assert_full_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_empty |-> (victim_pos == IDX_W'(DEPTH-1)));

  assert_empty_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_empty |-> (victim_addr == '0));

  assert_push_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (!hit && !miss));

endmodule

bind lru_mtf_stack lru_mtf_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_valid    (ref_valid),
  .ref_addr     (ref_addr),
  .ins_valid    (ins_valid),
  .ins_addr     (ins_addr),
  .hit          (hit),
  .miss         (miss),
  .hit_pos      (hit_pos),
  .victim_empty (victim_empty),
  .victim_pos   (victim_pos),
  .victim_addr  (victim_addr),
  .top_addr     (top_addr),
  .top_valid    (top_valid),
  .stack_flat   (stack_flat)
);

// File: tb/lru_mtf_stack_test.sv
`timescale 1ns/10ps
module lru_mtf_stack_test;

  localparam int N  = 8;
  localparam int AW = 12;
  localparam int IW = $clog2(N);

  // op codes: 0 reference, 1 push, 2 push together with a reference
  localparam int NV = 22;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 12'h000}, {2'd1, 12'h101}, {2'd1, 12'h102}, {2'd1, 12'h103},
    {2'd1, 12'h104}, {2'd1, 12'h105}, {2'd0, 12'h103}, {2'd0, 12'h103},
    {2'd0, 12'h1FF}, {2'd1, 12'h106}, {2'd1, 12'h107}, {2'd1, 12'h108},
    {2'd1, 12'h109}, {2'd0, 12'h102}, {2'd0, 12'h105}, {2'd2, 12'h10A},
    {2'd1, 12'h106}, {2'd0, 12'h106}, {2'd0, 12'h000}, {2'd1, 12'h10C},
    {2'd0, 12'h10C}, {2'd0, 12'h104}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0;
  logic [AW-1:0] ref_addr = '0;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic          hit, miss, victim_empty;
  logic [IW-1:0] hit_pos, victim_pos;
  logic [AW-1:0] victim_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_addr [N];
  bit            m_val  [N];

  always #2 clk = ~clk;

  lru_mtf_stack #(.DEPTH(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .hit(hit), .miss(miss),
    .hit_pos(hit_pos), .victim_empty(victim_empty), .victim_pos(victim_pos),
    .victim_addr(victim_addr)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(input logic [AW-1:0] a);
    for (int k = 0; k < N; k++) if (m_val[k] && m_addr[k] == a) return k;
    return -1;
  endfunction

  function automatic int model_count(input logic [AW-1:0] a);
    int c = 0;
    for (int k = 0; k < N; k++) if (m_val[k] && m_addr[k] == a) c++;
    return c;
  endfunction

  // Present a key during the low phase only; nothing is committed.
  task automatic probe(input logic [AW-1:0] a, output bit h, output int p);
    ref_valid = 1'b1; ins_valid = 1'b0; ref_addr = a;
    #0.1;
    h = hit; p = int'(hit_pos);
    ref_valid = 1'b0;
    #0.05;
  endtask

  task automatic verify_state(input string tag, input int split);
    bit h; int p; int cnt = 0;
    for (int j = 0; j < N; j++) begin
      if (m_val[j]) begin
        cnt++;
        probe(m_addr[j], h, p);
        chk((j > split) ? "R4" : tag, $sformatf("slot %0d present", j), int'(h), 1);
        chk((j > split) ? "R4" : tag, $sformatf("slot %0d position", j), p, model_find(m_addr[j]));
      end
    end
    probe(12'hEEE, h, p);
    chk("R10", "absent key", int'(h), 0);
    chk("R8", "victim_empty", int'(victim_empty), (cnt < N) ? 1 : 0);
    chk("R8", "victim_pos", int'(victim_pos), (cnt < N) ? cnt : N-1);
    chk("R8", "victim_addr", int'(victim_addr), (cnt < N) ? 0 : int'(m_addr[N-1]));
  endtask

  // Called in the low phase; ends in the next low phase.
  task automatic step(input logic [1:0] op, input logic [AW-1:0] a);
    int exp_pos; string tag; int split;
    exp_pos = model_find(a);
    split = N;
    ref_valid = (op != 2'd1);
    ins_valid = (op != 2'd0);
    ref_addr  = a;
    ins_addr  = (op == 2'd2) ? a + 1'b1 : a;
    #0.2;
    if (op == 2'd0) begin
      chk(exp_pos < 0 && a == 12'h000 ? "R10" : "R2", "hit", int'(hit), exp_pos >= 0);
      chk("R2", "miss", int'(miss), exp_pos < 0);
      if (exp_pos >= 0)
        chk(model_count(a) > 1 ? "R11" : "R2", "hit_pos", int'(hit_pos), exp_pos);
    end else begin
      chk("R9", "hit during push", int'(hit), 0);
      chk("R9", "miss during push", int'(miss), 0);
    end
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0; ins_valid = 1'b0;
    if (op == 2'd0) begin
      if (exp_pos > 0) begin
        logic [AW-1:0] t = m_addr[exp_pos];
        for (int k = exp_pos; k > 0; k--) m_addr[k] = m_addr[k-1];
        m_addr[0] = t;
        tag = "R3"; split = exp_pos;
      end else if (exp_pos == 0) tag = "R5";
      else tag = "R6";
    end else begin
      for (int k = N-1; k > 0; k--) begin
        m_addr[k] = m_addr[k-1]; m_val[k] = m_val[k-1];
      end
      m_addr[0] = (op == 2'd2) ? a + 1'b1 : a;
      m_val[0]  = 1'b1;
      tag = (op == 2'd2) ? "R9" : "R7";
    end
    verify_state(tag, split);
  endtask

  initial begin
    bit h; int p;
    for (int k = 0; k < N; k++) begin m_addr[k] = '0; m_val[k] = 1'b0; end
    repeat (2) @(negedge clk);
    chk("R1", "victim_empty in reset", int'(victim_empty), 1);
    chk("R1", "victim_pos in reset", int'(victim_pos), 0);
    chk("R1", "victim_addr in reset", int'(victim_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    probe(12'h000, h, p);
    chk("R1", "zero key after reset", int'(h), 0);

    for (int v = 0; v < NV; v++) step(VEC[v][13:12], VEC[v][11:0]);

    // Reset in the middle of a run clears a full stack.
    rst_n = 1'b0;
    #0.5;
    chk("R1", "victim_empty after mid reset", int'(victim_empty), 1);
    chk("R1", "victim_pos after mid reset", int'(victim_pos), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin m_addr[k] = '0; m_val[k] = 1'b0; end
    @(negedge clk);
    probe(12'h10C, h, p);
    chk("R1", "old page gone after reset", int'(h), 0);
    step(2'd0, 12'h000);
    step(2'd1, 12'h222);
    step(2'd0, 12'h222);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule